// File: doc/BRIEF.md
# Extended Field Address Generator

This block turns the 12-bit addresses of a small word-addressed processor into 15-bit memory addresses. Memory is split into eight fields of 4K words, and each field is split into pages of 128 words. For every memory access the processor gives the block the instruction word, the program counter, a phase code and, for indirect accesses, the pointer word it has read. The block returns the memory address for that phase, the address of the indirect pointer, the target of a jump, and a flag that marks pointers which must be incremented before use.

Two 3-bit field registers set the upper address bits. The code field covers instruction fetches, direct operands and pointer reads. The data field covers data reached through a pointer. A buffer holds a pending code field. The block decodes the field-change I/O instructions itself. A change to the code field waits in the buffer and only takes effect when a jump or subroutine call executes. Because of this, the field change never transfers control by itself.

Top module: `xfield_addr_gen`

## Requirements
- R1: When `phase_i` is 0 (fetch), or 3 (treated as fetch), `addr_o` is the code field concatenated with `pc_i`.
- R2: When `phase_i` is 1 (direct), the 12-bit operand address is formed from the 7-bit offset `instr_i[6:0]`. If `instr_i[7]` is 1, the upper five bits come from `pc_i[11:7]`. If it is 0, they are zero (page zero). `addr_o` is the code field followed by this operand address, and `ptr_addr_o` always carries the same value.
- R3: When `phase_i` is 2 (indirect), `ptr_addr_o` addresses the pointer word in the code field. `addr_o` is the data field followed by the pointer value.
- R4: An executed instruction whose bits `instr_i[11:6]` are octal 62 and whose bit 0 is set loads the data field with `instr_i[5:3]`. The new value is visible from the next cycle on.
- R5: An executed octal 62 instruction with bit 1 set writes `instr_i[5:3]` into the pending buffer only. The code field changes when the next executed JMP (opcode 5) or JMS (opcode 4) copies the buffer into it. With bits 0 and 1 both set, the data field is loaded at once and the code-field change is held in the same way.
- R6: A second code-field change issued before the jump replaces the pending value.
- R7: `jump_addr_o` is the pending field followed by the jump target. The target is the operand address when `instr_i[8]` is 0. When `instr_i[8]` is 1, it is the (possibly incremented) pointer value.
- R8: For an indirect memory-reference instruction (opcode 0 to 5, `instr_i[8]` set) whose pointer sits at operand address octal 10 to 17, the block does three things in the indirect phase: it raises `autoinc_o`, it drives `ptr_wdata_o` as `ptr_i` plus one, and it uses that incremented value as the address.
- R9: Reset clears the code field, the data field and the pending buffer to 0.
- R10: Field registers do not change when `exec_i` is low, or when an executed I/O instruction selects a device other than octal 2 in `instr_i[8:6]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| exec_i | input | 1 | Instruction in `instr_i` executes this cycle |
| phase_i | input | 2 | 0 fetch, 1 direct operand, 2 indirect operand, 3 fetch |
| instr_i | input | 12 | Current instruction word |
| pc_i | input | 12 | Program counter |
| ptr_i | input | 12 | Pointer word read for indirect access |
| addr_o | output | 15 | Memory address for the current phase |
| ptr_addr_o | output | 15 | Address of the indirect pointer word |
| jump_addr_o | output | 15 | Target of JMP/JMS under the pending field |
| autoinc_o | output | 1 | Pointer must be written back incremented |
| ptr_wdata_o | output | 12 | Incremented pointer for write-back |
| ifield_o | output | 3 | Current code field |
| dfield_o | output | 3 | Current data field |

## Verification
The address tests run with the data field and the code field holding different values. This shows which field each phase picks. Direct operands are tried with the page bit both set and clear, and with a program counter outside page zero. This separates current-page addressing from page-zero addressing. Indirect accesses through a plain pointer location are compared with accesses through an auto-increment location. Jumps are issued after one, two and combined field changes. These tests show the deferral, the overwrite of the pending value, and the indirect jump target landing in the new field.

// File: rtl/xfa_pkg.sv
package xfa_pkg;
  typedef enum logic [1:0] {
    PH_FETCH  = 2'd0,
    PH_DIRECT = 2'd1,
    PH_INDIR  = 2'd2,
    PH_RSVD   = 2'd3
  } phase_e;

  localparam logic [2:0] OP_JMS = 3'd4;
  localparam logic [2:0] OP_JMP = 3'd5;
  localparam logic [2:0] OP_IOT = 3'd6;
endpackage

// File: rtl/xfa_offset.sv
module xfa_offset #(
  parameter int WORD_W = 12,
  parameter int OFS_W  = 7
) (
  input  logic [WORD_W-1:0] instr_i,
  input  logic [WORD_W-1:0] pc_i,
  output logic [WORD_W-1:0] eff_o
);
  localparam int PAGE_W = WORD_W - OFS_W;

  always_comb begin
    if (instr_i[OFS_W]) eff_o = {pc_i[WORD_W-1:OFS_W], instr_i[OFS_W-1:0]};
    else                eff_o = {{PAGE_W{1'b0}}, instr_i[OFS_W-1:0]};
  end
endmodule

// File: rtl/xfa_field_regs.sv
module xfa_field_regs #(
  parameter int WORD_W          = 12,
  parameter int FIELD_W         = 3,
  parameter logic [2:0] DEV_SEL = 3'o2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               exec_i,
  input  logic [WORD_W-1:0]  instr_i,
  input  logic               is_jump_i,
  output logic [FIELD_W-1:0] if_o,
  output logic [FIELD_W-1:0] df_o,
  output logic [FIELD_W-1:0] ib_o
);
  import xfa_pkg::*;

  logic               iot_hit;
  logic [FIELD_W-1:0] new_fld;

  assign iot_hit = exec_i && (instr_i[WORD_W-1 -: 3] == OP_IOT)
                   && (instr_i[WORD_W-4 -: 3] == DEV_SEL);
  assign new_fld = instr_i[FIELD_W+2:3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      if_o <= '0;
      df_o <= '0;
      ib_o <= '0;
    end else begin
      if (iot_hit && instr_i[0]) df_o <= new_fld;
      if (iot_hit && instr_i[1]) ib_o <= new_fld;
      // pending field lands only on a control transfer
      if (exec_i && is_jump_i) if_o <= ib_o;
    end
  end
endmodule

// File: rtl/xfield_addr_gen.sv
module xfield_addr_gen #(
  parameter int WORD_W   = 12,
  parameter int FIELD_W  = 3,
  parameter int OFS_W    = 7,
  parameter int AI_BASE  = 8,
  parameter int AI_COUNT = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       exec_i,
  input  logic [1:0]                 phase_i,
  input  logic [WORD_W-1:0]          instr_i,
  input  logic [WORD_W-1:0]          pc_i,
  input  logic [WORD_W-1:0]          ptr_i,
  output logic [FIELD_W+WORD_W-1:0]  addr_o,
  output logic [FIELD_W+WORD_W-1:0]  ptr_addr_o,
  output logic [FIELD_W+WORD_W-1:0]  jump_addr_o,
  output logic                       autoinc_o,
  output logic [WORD_W-1:0]          ptr_wdata_o,
  output logic [FIELD_W-1:0]         ifield_o,
  output logic [FIELD_W-1:0]         dfield_o
);
  import xfa_pkg::*;

  localparam logic [WORD_W-1:0] AI_LO = WORD_W'(AI_BASE);
  localparam logic [WORD_W-1:0] AI_HI = WORD_W'(AI_BASE + AI_COUNT - 1);

  logic [WORD_W-1:0]  eff;
  logic [WORD_W-1:0]  ptr_eff;
  logic [FIELD_W-1:0] if_q, df_q, ib_q;
  logic [2:0]         opcode;
  logic               indir, memref, is_jump, ai_loc;

  assign opcode  = instr_i[WORD_W-1 -: 3];
  assign indir   = instr_i[OFS_W+1];
  assign memref  = (opcode < OP_IOT);
  assign is_jump = (opcode == OP_JMP) || (opcode == OP_JMS);

  xfa_offset #(.WORD_W(WORD_W), .OFS_W(OFS_W)) u_offset (
    .instr_i (instr_i),
    .pc_i    (pc_i),
    .eff_o   (eff)
  );

  xfa_field_regs #(.WORD_W(WORD_W), .FIELD_W(FIELD_W)) u_fields (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .exec_i    (exec_i),
    .instr_i   (instr_i),
    .is_jump_i (is_jump),
    .if_o      (if_q),
    .df_o      (df_q),
    .ib_o      (ib_q)
  );

  assign ai_loc  = memref && indir && (eff >= AI_LO) && (eff <= AI_HI);
  assign ptr_eff = ai_loc ? ptr_i + 1'b1 : ptr_i;

  always_comb begin
    unique case (phase_e'(phase_i))
      PH_DIRECT: addr_o = {if_q, eff};
      PH_INDIR:  addr_o = {df_q, ptr_eff};
      default:   addr_o = {if_q, pc_i};
    endcase
  end

  assign ptr_addr_o  = {if_q, eff};
  assign jump_addr_o = {ib_q, (indir ? ptr_eff : eff)};
  assign autoinc_o   = ai_loc && (phase_e'(phase_i) == PH_INDIR);
  assign ptr_wdata_o = ptr_eff;
  assign ifield_o    = if_q;
  assign dfield_o    = df_q;
endmodule

// File: rtl/xfield_addr_gen_chk.sv
module xfield_addr_gen_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        exec_i,
  input logic [1:0]  phase_i,
  input logic [11:0] instr_i,
  input logic [11:0] pc_i,
  input logic [11:0] ptr_i,
  input logic [14:0] addr_o,
  input logic [14:0] jump_addr_o,
  input logic        autoinc_o,
  input logic [2:0]  ifield_o,
  input logic [2:0]  dfield_o
);
  logic jmp_exec, cdf_exec;
  assign jmp_exec = exec_i && (instr_i[11:9] == 3'd4 || instr_i[11:9] == 3'd5);
  assign cdf_exec = exec_i && (instr_i[11:6] == 6'o62) && instr_i[0];

  assert_fetch_addr_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == 2'd0) |-> (addr_o == {ifield_o, pc_i}));

  assert_cdf_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cdf_exec |=> (dfield_o == $past(instr_i[5:3])));

  assert_if_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !jmp_exec |=> $stable(ifield_o));

  assert_jump_field_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jmp_exec |=> (ifield_o == $past(jump_addr_o[14:12])));

  assert_autoinc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    autoinc_o |-> (addr_o == {dfield_o, ptr_i + 12'd1}));

  assert_df_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |=> $stable(dfield_o));
endmodule

bind xfield_addr_gen xfield_addr_gen_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .exec_i      (exec_i),
  .phase_i     (phase_i),
  .instr_i     (instr_i),
  .pc_i        (pc_i),
  .ptr_i       (ptr_i),
  .addr_o      (addr_o),
  .jump_addr_o (jump_addr_o),
  .autoinc_o   (autoinc_o),
  .ifield_o    (ifield_o),
  .dfield_o    (dfield_o)
);

// File: tb/xfield_addr_gen_bench.sv
`timescale 1ns/1ps
module xfield_addr_gen_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        exec_i = 1'b0;
  logic [1:0]  phase_i = 2'd0;
  logic [11:0] instr_i = '0, pc_i = '0, ptr_i = '0;
  logic [14:0] addr_o, ptr_addr_o, jump_addr_o;
  logic        autoinc_o;
  logic [11:0] ptr_wdata_o;
  logic [2:0]  ifield_o, dfield_o;
  int checks = 0, errors = 0;

  always #2.5 clk_i = ~clk_i;

  xfield_addr_gen u_xfield_addr_gen (.*);

  typedef struct packed {
    logic [1:0]  ph;
    logic [11:0] ins;
    logic [11:0] pc;
    logic [11:0] ptr;
    logic [14:0] exp_addr;
    logic [14:0] exp_ptr;
    logic        exp_ai;
  } vec_t;

  // code field 0, data field 5 while walking this table
  localparam vec_t VECS [7] = '{
    '{2'd0, 12'o7000, 12'o1234, 12'o0000, 15'o01234, 15'o00000, 1'b0}, // R1
    '{2'd3, 12'o7000, 12'o4321, 12'o0000, 15'o04321, 15'o00000, 1'b0}, // R1 phase 3
    '{2'd1, 12'o1045, 12'o2345, 12'o0000, 15'o00045, 15'o00045, 1'b0}, // R2 page zero
    '{2'd1, 12'o1245, 12'o2345, 12'o0000, 15'o02245, 15'o02245, 1'b0}, // R2 current page
    '{2'd2, 12'o1445, 12'o2345, 12'o7000, 15'o57000, 15'o00045, 1'b0}, // R3
    '{2'd2, 12'o1412, 12'o2345, 12'o0777, 15'o51000, 15'o00012, 1'b1}, // R8
    '{2'd1, 12'o1012, 12'o2345, 12'o0777, 15'o00012, 15'o00012, 1'b0}  // R8 direct: no inc
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0o expected=%0o", req, act, exp);
    end
  endtask

  task automatic drive(input logic ex, input logic [1:0] ph, input logic [11:0] ins,
                       input logic [11:0] pc, input logic [11:0] ptr);
    @(negedge clk_i);
    exec_i = ex; phase_i = ph; instr_i = ins; pc_i = pc; ptr_i = ptr;
    #1;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #12 rst_ni = 1'b1;
    drive(0, 2'd0, 12'o7000, 12'o0200, 0);
    chk("R9 if", ifield_o, 0);
    chk("R9 df", dfield_o, 0);
    chk("R1 reset fetch", addr_o, 15'o00200);

    drive(1, 2'd0, 12'o6251, 0, 0);           // data field := 5
    drive(0, 2'd0, 12'o7000, 0, 0);
    chk("R4 df", dfield_o, 5);
    chk("R4 if unchanged", ifield_o, 0);
    drive(0, 2'd0, 12'o6231, 0, 0);           // not executed
    drive(1, 2'd0, 12'o6331, 0, 0);           // other device
    drive(0, 2'd0, 12'o7000, 0, 0);
    chk("R10 df", dfield_o, 5);
    chk("R10 if", ifield_o, 0);

    foreach (VECS[i]) begin
      drive(0, VECS[i].ph, VECS[i].ins, VECS[i].pc, VECS[i].ptr);
      chk("R1/R2/R3/R8 addr", addr_o, VECS[i].exp_addr);
      chk("R2/R3 ptr_addr", ptr_addr_o, VECS[i].exp_ptr);
      chk("R8 autoinc", autoinc_o, VECS[i].exp_ai);
    end
    drive(0, 2'd2, 12'o1412, 0, 12'o0777);
    chk("R8 wdata", ptr_wdata_o, 12'o1000);

    drive(1, 2'd0, 12'o6232, 0, 0);           // pending code field 3
    drive(0, 2'd0, 12'o5020, 12'o0100, 0);
    chk("R5 if deferred", ifield_o, 0);
    chk("R5 fetch old field", addr_o, 15'o00100);
    chk("R7 jump pending", jump_addr_o, 15'o30020);
    drive(1, 2'd0, 12'o6242, 0, 0);           // overwrite with 4
    drive(0, 2'd0, 12'o5020, 12'o0100, 0);
    chk("R6 overwrite", jump_addr_o, 15'o40020);
    chk("R6 if still", ifield_o, 0);
    drive(1, 2'd0, 12'o5020, 12'o0100, 0);    // JMP applies field
    drive(0, 2'd0, 12'o7000, 12'o0100, 0);
    chk("R5 if applied", ifield_o, 4);
    chk("R1 new field fetch", addr_o, 15'o40100);

    drive(1, 2'd0, 12'o6262, 0, 0);           // pending 6
    drive(0, 2'd2, 12'o4410, 0, 12'o3333);    // JMS indirect via auto-inc loc
    chk("R7 indirect target", jump_addr_o, 15'o63334);
    chk("R3 ptr in old field", ptr_addr_o, 15'o40010);
    drive(1, 2'd2, 12'o4410, 0, 12'o3333);
    drive(0, 2'd0, 12'o7000, 0, 0);
    chk("R7 if after JMS", ifield_o, 6);

    drive(1, 2'd0, 12'o6273, 0, 0);           // both fields 7
    drive(0, 2'd0, 12'o5000, 0, 0);
    chk("R5 combined df", dfield_o, 7);
    chk("R5 combined if held", ifield_o, 6);
    chk("R7 combined target", jump_addr_o, 15'o70000);
    drive(1, 2'd0, 12'o5000, 0, 0);
    drive(0, 2'd0, 12'o7000, 0, 0);
    chk("R5 combined if", ifield_o, 7);

    drive(1, 2'd0, 12'o6212, 0, 0);           // pending 1
    drive(0, 2'd0, 12'o7000, 0, 0);
    rst_ni = 1'b0;
    #1;
    chk("R9 if", ifield_o, 0);
    chk("R9 df", dfield_o, 0);
    drive(0, 2'd0, 12'o5000, 0, 0);
    rst_ni = 1'b1;
    #1;
    chk("R9 pending cleared", jump_addr_o, 15'o00000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule